// File: doc/BRIEF.md
# Configurable UART Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame. A one-byte holding stage takes a character from an upstream FIFO or register through a valid strobe. Whenever the shifter is idle, the held character moves into it. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit and a stop period. Then the line returns to its high idle level.

A line-control byte sets the frame shape. A small register port on the block writes that byte and the 16-bit bit-rate divisor. An internal counter divides the clock by the divisor to make an oversampling tick, and sixteen ticks make one bit time. Two status outputs report whether the holding stage is free and whether the whole transmit path has drained. System software uses them to decide when to feed the next character and when the line is quiet.

Top module: `uart_char_tx`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits least significant first; line-control bits [1:0] give the data width as 5 + value (00 gives 5 bits, 11 gives 8 bits).
- R2: Line-control bit 2 clear gives a one-bit stop period. Set, it gives two stop bits, except with a 5-bit width, where it gives 1.5 bit times. The stop period is high, and the shifter reports idle at its end.
- R3: Line-control bit 3 adds a parity bit after the data. With bit 5 clear, bit 4 set makes the count of ones in data plus parity even, and bit 4 clear makes it odd. With bit 5 set, the parity bit is the inverse of bit 4.
- R4: Line-control bit 6 drives the serial output low two clock cycles after the write, for as long as it is set, whatever the frame state is.
- R5: After reset, and whenever no frame is in progress and bit 6 is clear, the serial output is high. Reset leaves both status outputs high.
- R6: While line-control bit 7 is set, writes to offset 0 load the low divisor byte and writes to offset 1 load the high byte. While it is clear, writes to these offsets leave the divisor unchanged. The line-control byte sits at offset 3. One bit lasts 16 x divisor clock cycles.
- R7: A divisor of 0 stops the bit-rate counter. A waiting character stays in the holding stage and the line stays high until a nonzero divisor is loaded.
- R8: hold_empty falls in the cycle after a character is accepted and rises when that character moves into the idle shifter. A valid character offered while the holding stage is full is dropped.
- R9: shift_empty is high only when the holding stage is empty and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| ch_valid | input | 1 | Character offered |
| ch_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding stage free |
| shift_empty | output | 1 | Holding stage and shifter both idle |

## Verification
A wrong phase in the tick or bit counters shows up as a bit edge in the wrong cycle. Every bit centre is therefore sampled, and the cycle in which shift_empty rises is compared exactly against 16 x divisor x bits plus the stop time, so a one-tick error is reported within the same frame. A wrong width, parity or stop decode gives a wrong level at a bit centre, or an end-of-frame time that is off by a whole or half bit, so all 64 frame shapes are swept. A holding stage that is overwritten or never drained shows as a wrong second character, or as a spurious third frame on a line that should stay idle.

// File: rtl/uart_char_tx_pkg.sv
package uart_char_tx_pkg;

  typedef struct packed {
    logic       dlab;      // divisor byte access
    logic       brk;       // force spacing
    logic       stick;     // fixed parity
    logic       even;      // even select
    logic       par_en;    // parity bit present
    logic       two_stop;  // long stop period
    logic [1:0] wlen;      // data width - 5
  } line_ctl_t;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP
  } fstate_t;

  function automatic logic calc_parity(logic [7:0] d, line_ctl_t c);
    logic [7:0] m;
    logic       x;
    m = d & (8'hFF >> (2'd3 - c.wlen));
    x = ^m;
    if (c.stick) return ~c.even;
    return c.even ? x : ~x;
  endfunction

endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_char_tx_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter int          DIV_W    = 16,
  parameter int          LCR_ADDR = 3,
  parameter logic [7:0]  RST_LCR  = 8'h03,
  parameter logic [15:0] RST_DIV  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output line_ctl_t         lcr,
  output logic [DIV_W-1:0]  div
);

  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LCR = ADDR_W'(LCR_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr <= line_ctl_t'(RST_LCR);
      div <= DIV_W'(RST_DIV);
    end else if (we) begin
      if (addr == A_LCR) lcr <= line_ctl_t'(wdata);
      if (addr == A_LO && lcr.dlab) div[7:0] <= wdata;
      if (addr == A_HI && lcr.dlab) div[DIV_W-1:8] <= wdata[DIV_W-9:0];
    end
  end

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == A_LO || addr == A_HI) && !lcr.dlab) |=> (div == $past(div))); // R6

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (div != '0) && (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || sync || div == '0 || tick) cnt <= '0;
    else                                  cnt <= cnt + DIV_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div > DIV_W'(1) && !sync) |=> !tick); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (div != '0 && $stable(div)) |=> (cnt < div || !$stable(div))); // R6

  AST_DIV0_STILL: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> (cnt == '0)); // R7

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_char_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      div_zero,
  input  line_ctl_t lcr,
  input  logic      ch_valid,
  input  logic [7:0] ch_data,
  output logic      load,
  output logic      txd,
  output logic      hold_empty,
  output logic      shift_empty
);

  localparam int CW = $clog2(2 * OVS + 1);
  localparam logic [CW-1:0] LIM_ONE  = CW'(OVS);
  localparam logic [CW-1:0] LIM_HALF = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OVS);

  fstate_t       state;
  logic [CW-1:0] tcnt, stop_lim, lim;
  logic [2:0]    bitn, nlast;
  logic [7:0]    shreg, hold_data;
  logic          hold_full, pen, pbit, line_bit;
  logic          unused_dlab;

  assign unused_dlab = lcr.dlab;
  assign load        = hold_full && (state == FS_IDLE) && !div_zero;
  assign lim         = (state == FS_STOP) ? stop_lim : LIM_ONE;
  assign hold_empty  = !hold_full;
  assign shift_empty = !hold_full && (state == FS_IDLE);

  always_comb begin
    case (state)
      FS_START: line_bit = 1'b0;
      FS_DATA:  line_bit = shreg[0];
      FS_PAR:   line_bit = pbit;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      tcnt      <= '0;
      stop_lim  <= LIM_ONE;
      bitn      <= '0;
      nlast     <= '0;
      shreg     <= '0;
      hold_data <= '0;
      hold_full <= 1'b0;
      pen       <= 1'b0;
      pbit      <= 1'b0;
      txd       <= 1'b1;
    end else begin
      txd <= lcr.brk ? 1'b0 : line_bit;
      if (load) begin
        hold_full <= 1'b0;
      end else if (ch_valid && !hold_full) begin
        hold_full <= 1'b1;
        hold_data <= ch_data;
      end
      if (load) begin
        state    <= FS_START;
        tcnt     <= '0;
        bitn     <= '0;
        shreg    <= hold_data;
        nlast    <= 3'd4 + {1'b0, lcr.wlen};
        pen      <= lcr.par_en;
        pbit     <= calc_parity(hold_data, lcr);
        stop_lim <= !lcr.two_stop ? LIM_ONE :
                    (lcr.wlen == 2'd0) ? LIM_HALF : LIM_TWO;
      end else if (tick && state != FS_IDLE) begin
        if (tcnt != lim - CW'(1)) begin
          tcnt <= tcnt + CW'(1);
        end else begin
          tcnt <= '0;
          case (state)
            FS_START: state <= FS_DATA;
            FS_DATA: begin
              shreg <= {1'b0, shreg[7:1]};
              bitn  <= bitn + 3'd1;
              if (bitn == nlast) state <= pen ? FS_PAR : FS_STOP;
            end
            FS_PAR:  state <= FS_STOP;
            default: state <= FS_IDLE;
          endcase
        end
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == FS_START && !lcr.brk) |=> !txd); // R1

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    lcr.brk |=> !txd); // R4

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (shift_empty && !lcr.brk) |=> txd); // R5

  AST_DIV0_WAIT: assert property (@(posedge clk) disable iff (rst)
    (div_zero && state == FS_IDLE) |=> (state == FS_IDLE)); // R7

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !load) |=> (hold_full && hold_data == $past(hold_data))); // R8

endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_char_tx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);

  line_ctl_t        lcr;
  logic [DIV_W-1:0] div;
  logic             tick, load;

  uart_tx_cfg #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .lcr(lcr), .div(div)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .sync(load), .div(div), .tick(tick)
  );

  uart_tx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst(rst), .tick(tick), .div_zero(div == '0), .lcr(lcr),
    .ch_valid(ch_valid), .ch_data(ch_data), .load(load), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

endmodule

// File: tb/sim_uart_char_tx.sv
module sim_uart_char_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ch_valid = 1'b0;
  logic [7:0] ch_data = '0;
  logic       txd, hold_empty, shift_empty;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_char_tx u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ch_valid(ch_valid), .ch_data(ch_data),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic set_div(input logic [15:0] dv);
    wr(3'd3, 8'h83);
    wr(3'd1, dv[15:8]);
    wr(3'd0, dv[7:0]);
    wr(3'd3, 8'h03);
  endtask

  task automatic put_char(input logic [7:0] d);
    while (!hold_empty) @(negedge clk);
    ch_valid = 1'b1; ch_data = d;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic observe(input logic [7:0] l, input logic [7:0] d, input int dv,
                         input bit end_chk, input string tag);
    int n, p, nb, stopt, t0, x, par, e;
    n = 5 + l[1:0];
    p = l[3];
    x = ^(d & (8'hFF >> (3 - l[1:0])));
    par = l[5] ? !l[4] : (l[4] ? x : !x);
    nb = 1 + n + p;
    stopt = !l[2] ? 16 : (n == 5 ? 24 : 32);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    for (int k = 0; k < nb; k++) begin
      wait_cyc(t0 + 16 * dv * k + 8 * dv);
      e = (k == 0) ? 0 : (k <= n) ? d[k-1] : par;
      if (k <= n) chk(txd, e, "R1", $sformatf("%s lcr %0h bit %0d", tag, l, k));
      else        chk(txd, e, "R3", $sformatf("%s lcr %0h parity", tag, l));
    end
    wait_cyc(t0 + 16 * dv * nb + 4 * dv);
    chk(txd, 1, "R2", $sformatf("%s lcr %0h stop start", tag, l));
    wait_cyc(t0 + 16 * dv * nb + (stopt - 4) * dv);
    chk(txd, 1, "R2", $sformatf("%s lcr %0h stop end", tag, l));
    if (end_chk) begin
      while (!shift_empty) @(negedge clk);
      chk(cyc - t0, (16 * nb + stopt) * dv - 1, "R2",
          $sformatf("%s lcr %0h frame length (R9 idle)", tag, l));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd, 1, "R5", "reset line");
    chk(hold_empty, 1, "R5", "reset hold_empty");
    chk(shift_empty, 1, "R5", "reset shift_empty");

    set_div(16'd2);
    wr(3'd0, 8'h55);
    wr(3'd1, 8'h77);
    put_char(8'h3C);
    observe(8'h03, 8'h3C, 2, 1, "R6 ignored divisor write");

    for (int l = 0; l < 64; l++) begin
      wr(3'd3, 8'(l));
      put_char(8'((l * 37 + 11) & 255));
      observe(8'(l), 8'((l * 37 + 11) & 255), 2, 1, "sweep");
    end

    wr(3'd3, 8'h03);
    ch_valid = 1'b1; ch_data = 8'h96;
    fork
      observe(8'h03, 8'h96, 2, 0, "R8 first");
      begin
        @(negedge clk);
        ch_valid = 1'b0;
        chk(hold_empty, 0, "R8", "full after accept");
        @(negedge clk);
        chk(hold_empty, 1, "R8", "free after move");
        ch_valid = 1'b1; ch_data = 8'h2D;
        @(negedge clk);
        ch_data = 8'hE1;
        chk(hold_empty, 0, "R8", "second held");
        chk(shift_empty, 0, "R9", "busy path");
        repeat (3) @(negedge clk);
        ch_valid = 1'b0;
      end
    join
    observe(8'h03, 8'h2D, 2, 1, "R8 second");
    repeat (100) @(negedge clk);
    chk(txd, 1, "R8", "dropped char not sent");
    chk(hold_empty, 1, "R8", "nothing left held");

    put_char(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    wait_cyc(cyc + 96);
    wr(3'd3, 8'h43);
    @(negedge clk);
    chk(txd, 0, "R4", "break asserted");
    repeat (20) @(negedge clk);
    chk(txd, 0, "R4", "break held");
    wr(3'd3, 8'h03);
    while (!shift_empty) @(negedge clk);
    @(negedge clk);
    chk(txd, 1, "R5", "idle after break");

    wr(3'd3, 8'h80);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h03);
    put_char(8'hA5);
    repeat (60) @(negedge clk);
    chk(txd, 1, "R7", "divisor 0 line");
    chk(hold_empty, 0, "R7", "divisor 0 holds");
    chk(shift_empty, 0, "R7", "divisor 0 not drained");
    wr(3'd3, 8'h83);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h02);
    observe(8'h03, 8'hA5, 2, 1, "R7 resume");
    wr(3'd3, 8'h03);

    wr(3'd3, 8'h80);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h03);
    put_char(8'hFF);
    begin
      int t0;
      while (txd !== 1'b0) @(negedge clk);
      t0 = cyc;
      wait_cyc(t0 + 4090);
      chk(txd, 0, "R6", "high byte start bit");
      wait_cyc(t0 + 4100);
      chk(txd, 1, "R6", "high byte first data");
      while (!shift_empty) @(negedge clk);
      chk(cyc - t0, 160 * 256 - 1, "R6", "high byte frame length");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule